// File: doc/BRIEF.md
# Video Input Half-Rate Phase Aligner

This block sits at the entry of a digital video front end. It turns a byte-rate input clock into a pixel-rate clock enable and splits the incoming sample stream into paired luma and chroma samples. In the 16-bit 4:2:2 mode, luma and chroma arrive on separate buses and every input clock carries a pixel. In the 8-bit multiplexed mode and the embedded-sync mode, one byte arrives per clock in the order Cb, Y, Cr, Y. The enable then runs at half rate, and each chroma byte is paired with the luma byte that follows it.

The half-rate phase is re-aligned once per line. In the 8-bit mode the line event is a selected horizontal sync transition, seen through a two-stage synchronizer and delayed by two more clocks. In the embedded-sync mode the line event is a start-of-active-video code in the data stream. A chroma-invert control shifts the alignment by one input clock when the sync-to-chroma distance is odd. A new mode or a new invert setting takes effect only at a line event.

Top module: `vid_half_rate_aligner`

## Requirements
- R1: While rst_ni is low, pix_en_o, phase_o, c_is_cr_o, y_o and c_o are all 0. After reset, the active mode is full rate (mode code 2'b00) until the first line event.
- R2: In full-rate mode (mode 2'b00), pix_en_o is high after every clock edge. At each edge, y_o and c_o load the values of data_i and chroma_i present before that edge, and c_is_cr_o alternates 0, 1, 0, ... starting from 0 after reset.
- R3: In the divided modes (mode 2'b01 is 8-bit, 2'b10 is embedded sync, 2'b11 behaves as 2'b01), pix_en_o is high after at most one edge in any two consecutive edges, except at a line event.
- R4: In a sync-driven mode, a selected hsync_i transition applied between edges k-1 and k produces a line event. After edge k+4, phase_o equals chroma_inv_i. phase_o is 1 while the byte currently on data_i is taken as luma.
- R5: The selected transition is a rising hsync_i when sync_pol_i equals edge_sel_i, and a falling one otherwise. The opposite transition leaves the phase unchanged.
- R6: With chroma_inv_i at 0, the byte after the line-event edge is chroma. At the edge that samples the next byte, pix_en_o rises with c_o holding the first byte and y_o the second. c_is_cr_o encodes 0 for Cb and 1 for Cr, and it starts at Cb and alternates on each pair.
- R7: With chroma_inv_i at 1, pairing shifts by one input clock. The byte after the line-event edge is taken as luma. The first complete pair is formed from the second and third bytes and is flagged Cb.
- R8: In embedded-sync mode, the byte sequence FF, 00, 00, XY with XY bit 4 equal to 0 makes the edge that samples XY the line event. The byte after XY is the first chroma. A code with bit 4 equal to 1 causes no line event.
- R9: In embedded-sync mode, hsync_i transitions cause no line event.
- R10: A new mode_i value takes effect only at a line event. Between line events, the pix_en_o pattern follows the mode latched at the last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte-rate input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous to clk_i |
| data_i | input | 8 | Multiplexed byte stream, or luma in full-rate mode |
| chroma_i | input | 8 | Chroma bus used only in full-rate mode |
| mode_i | input | 2 | 00 full rate, 01 8-bit, 10 embedded sync, 11 as 01 |
| sync_pol_i | input | 1 | Sync polarity: 0 positive, 1 negative |
| edge_sel_i | input | 1 | 0 leading edge, 1 trailing edge |
| chroma_inv_i | input | 1 | Shift the pairing by one input clock |
| pix_en_o | output | 1 | Pixel-rate enable, one clock wide |
| phase_o | output | 1 | 1 while the current byte is taken as luma |
| y_o | output | 8 | Luma sample of the current pixel |
| c_o | output | 8 | Chroma sample of the current pixel |
| c_is_cr_o | output | 1 | 0 when c_o is Cb, 1 when Cr |

## Verification
The bench drives each of the four polarity and edge-select combinations. It then sends the opposite transition so that its would-be line event lands on an odd edge. A design that reacts to the wrong edge, or counts one clock too many or too few, flips phase_o there or pairs each chroma byte with the wrong luma byte. In embedded-sync mode, an end-of-video code and an hsync rise are timed to land at the same odd edge. A decoder that ignores the H bit, or a mux that still follows the sync pin, therefore shows up as a flipped phase. A mode change made without a line event has to leave the full-rate enable untouched. A design that applies the mode at once would halve the enable.

// File: rtl/vhr_pkg.sv
package vhr_pkg;
  typedef enum logic [1:0] {
    VHR_FULL  = 2'b00,
    VHR_MUX8  = 2'b01,
    VHR_EMBED = 2'b10,
    VHR_MUX8B = 2'b11
  } vhr_mode_e;

  function automatic logic vhr_is_full(input logic [1:0] m);
    return m == VHR_FULL;
  endfunction

  function automatic logic vhr_is_embed(input logic [1:0] m);
    return m == VHR_EMBED;
  endfunction
endpackage

// File: rtl/vhr_sync_edge.sv
module vhr_sync_edge #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned DELAY  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pol_i,
  input  logic edge_sel_i,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              want_rise;
  logic              det;
  logic [DELAY-1:0]  dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sync_i};
      prev_q <= sync_q[LAST];
    end
  end

  // leading/trailing combined with polarity resolves to a single direction
  assign want_rise = ~(pol_i ^ edge_sel_i);
  assign det = en_i && (sync_q[LAST] != prev_q) && (sync_q[LAST] == want_rise);

  for (genvar i = 0; i < DELAY; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[i] <= 1'b0;
      else if (i == 0) dly_q[i] <= det;
      else dly_q[i] <= dly_q[(i == 0) ? 0 : i-1];
    end
  end

  assign pulse_o = dly_q[DELAY-1];
endmodule

// File: rtl/vhr_sav_detect.sv
module vhr_sav_detect #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned H_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sav_o
);
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic [DATA_W-1:0] b1_q, b2_q, b3_q;
  logic              preamble;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= '0;
      b2_q <= '0;
      b3_q <= '0;
    end else begin
      b1_q <= data_i;
      b2_q <= b1_q;
      b3_q <= b2_q;
    end
  end

  assign preamble = (b3_q == ONES) && (b2_q == ZEROS) && (b1_q == ZEROS);
  // code byte is on data_i now; H bit low marks start of active video
  assign sav_o = en_i && preamble && !data_i[H_BIT];
endmodule

// File: rtl/vhr_phase_div.sv
module vhr_phase_div
  import vhr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_rst_i,
  input  logic [1:0] mode_i,
  input  logic       inv_i,
  output logic [1:0] mode_q_o,
  output logic       full_o,
  output logic       ph_o
);
  logic [1:0] mode_q;
  logic       ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= VHR_FULL;
      ph_q   <= 1'b0;
    end else if (line_rst_i) begin
      mode_q <= mode_i;
      ph_q   <= inv_i;
    end else begin
      ph_q   <= ~ph_q;
    end
  end

  assign mode_q_o = mode_q;
  assign full_o   = vhr_is_full(mode_q);
  assign ph_o     = ph_q;
endmodule

// File: rtl/vhr_demux.sv
module vhr_demux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_i,
  input  logic              ph_i,
  input  logic              line_rst_i,
  input  logic              cr_init_i,
  input  logic [DATA_W-1:0] luma_i,
  input  logic [DATA_W-1:0] chroma_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] c_o,
  output logic              cr_o,
  output logic              en_o
);
  logic              take;
  logic              cr_q;
  logic [DATA_W-1:0] hold_q;

  assign take = full_i | ph_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o    <= '0;
      c_o    <= '0;
      cr_o   <= 1'b0;
      en_o   <= 1'b0;
      cr_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      en_o <= take;
      if (take) begin
        y_o  <= luma_i;
        c_o  <= full_i ? chroma_i : hold_q;
        cr_o <= cr_q;
      end else begin
        hold_q <= luma_i;
      end
      if (line_rst_i) cr_q <= cr_init_i;
      else if (take)  cr_q <= ~cr_q;
    end
  end
endmodule

// File: rtl/vid_half_rate_aligner.sv
module vid_half_rate_aligner
  import vhr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYNC_DELAY  = 2,
  parameter int unsigned H_BIT       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] chroma_i,
  input  logic [1:0]        mode_i,
  input  logic              sync_pol_i,
  input  logic              edge_sel_i,
  input  logic              chroma_inv_i,
  output logic              pix_en_o,
  output logic              phase_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] c_o,
  output logic              c_is_cr_o
);
  logic       use_sav;
  logic       sync_pulse;
  logic       sav_pulse;
  logic       line_rst;
  logic [1:0] mode_q;
  logic       full;
  logic       ph;
  logic       cr_init;

  assign use_sav = vhr_is_embed(mode_i);

  vhr_sync_edge #(
    .STAGES (SYNC_STAGES),
    .DELAY  (SYNC_DELAY)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (hsync_i),
    .pol_i      (sync_pol_i),
    .edge_sel_i (edge_sel_i),
    .en_i       (!use_sav),
    .pulse_o    (sync_pulse)
  );

  vhr_sav_detect #(
    .DATA_W (DATA_W),
    .H_BIT  (H_BIT)
  ) u_sav (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (use_sav),
    .data_i (data_i),
    .sav_o  (sav_pulse)
  );

  assign line_rst = sync_pulse | sav_pulse;
  // a leftover half pair after an inverted reset is flagged Cr so the first full pair is Cb
  assign cr_init  = chroma_inv_i && !vhr_is_full(mode_i);

  vhr_phase_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_rst_i (line_rst),
    .mode_i     (mode_i),
    .inv_i      (chroma_inv_i),
    .mode_q_o   (mode_q),
    .full_o     (full),
    .ph_o       (ph)
  );

  vhr_demux #(
    .DATA_W (DATA_W)
  ) u_demux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_i     (full),
    .ph_i       (ph),
    .line_rst_i (line_rst),
    .cr_init_i  (cr_init),
    .luma_i     (data_i),
    .chroma_i   (chroma_i),
    .y_o        (y_o),
    .c_o        (c_o),
    .cr_o       (c_is_cr_o),
    .en_o       (pix_en_o)
  );

  assign phase_o = ph;
endmodule

// File: rtl/vhr_aligner_checker.sv
module vhr_aligner_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned H_BIT  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_q,
  input logic [1:0]        mode_i,
  input logic              line_rst,
  input logic              phase_o,
  input logic              pix_en_o,
  input logic              chroma_inv_i,
  input logic [DATA_W-1:0] data_i
);
  // R2
  a_r2_full_rate_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |=> pix_en_o);

  // R3
  a_r3_en_follows_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 2'b00 && !phase_o && !line_rst) |=> !pix_en_o);

  // R4
  a_r4_phase_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_rst |=> (phase_o == $past(chroma_inv_i)));

  // R8
  a_r8_no_lock_on_eav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && line_rst) |-> !data_i[H_BIT]);

  // R10
  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_rst |=> $stable(mode_q));
endmodule

bind vid_half_rate_aligner vhr_aligner_checker #(
  .DATA_W (DATA_W),
  .H_BIT  (H_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_q       (mode_q),
  .mode_i       (mode_i),
  .line_rst     (line_rst),
  .phase_o      (phase_o),
  .pix_en_o     (pix_en_o),
  .chroma_inv_i (chroma_inv_i),
  .data_i       (data_i)
);

// File: tb/vid_half_rate_aligner_bench.sv
module vid_half_rate_aligner_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] chroma_i = '0;
  logic [1:0] mode_i = 2'b00;
  logic       sync_pol_i = 1'b0;
  logic       edge_sel_i = 1'b0;
  logic       chroma_inv_i = 1'b0;
  logic       pix_en_o, phase_o, c_is_cr_o;
  logic [7:0] y_o, c_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ry [6];
  logic [7:0] rc [6];
  logic       ren [6];
  logic       rcr [6];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vid_half_rate_aligner u_vid_half_rate_aligner (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .data_i(data_i),
    .chroma_i(chroma_i), .mode_i(mode_i), .sync_pol_i(sync_pol_i),
    .edge_sel_i(edge_sel_i), .chroma_inv_i(chroma_inv_i),
    .pix_en_o(pix_en_o), .phase_o(phase_o), .y_o(y_o), .c_o(c_o),
    .c_is_cr_o(c_is_cr_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // feed 0x10.. after a line event and check pairs (R6 / R7)
  task automatic feed_and_check_pairs(string tag, logic inv);
    int base;
    for (int i = 0; i < 6; i++) begin
      data_i = 8'h10 + 8'(i);
      tick();
      ry[i] = y_o; rc[i] = c_o; ren[i] = pix_en_o; rcr[i] = c_is_cr_o;
    end
    base = inv ? 2 : 1;
    chk({tag, " en first pair"}, {7'd0, ren[base]}, 8'd1);
    chk({tag, " c first pair"}, rc[base], 8'h10 + 8'(base - 1));
    chk({tag, " y first pair"}, ry[base], 8'h10 + 8'(base));
    chk({tag, " first pair is Cb"}, {7'd0, rcr[base]}, 8'd0);
    chk({tag, " en gap (R3)"}, {7'd0, ren[base+1]}, 8'd0);
    chk({tag, " c second pair"}, rc[base+2], 8'h10 + 8'(base + 1));
    chk({tag, " y second pair"}, ry[base+2], 8'h10 + 8'(base + 2));
    chk({tag, " second pair is Cr"}, {7'd0, rcr[base+2]}, 8'd1);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 pix_en", {7'd0, pix_en_o}, 8'd0);
    chk("R1 phase", {7'd0, phase_o}, 8'd0);
    chk("R1 cr flag", {7'd0, c_is_cr_o}, 8'd0);
    chk("R1 y", y_o, 8'd0);
    chk("R1 c", c_o, 8'd0);
    rst_ni = 1'b1;
  endtask

  task automatic test_full_rate();
    for (int i = 0; i < 3; i++) begin
      data_i = 8'hA0 + 8'(i);
      chroma_i = 8'hC0 + 8'(i);
      tick();
      chk("R2 en", {7'd0, pix_en_o}, 8'd1);
      chk("R2 y", y_o, 8'hA0 + 8'(i));
      chk("R2 c", c_o, 8'hC0 + 8'(i));
      chk("R2 cr alt", {7'd0, c_is_cr_o}, {7'd0, 1'(i & 1)});
    end
  endtask

  task automatic test_mode_deferred();
    mode_i = 2'b01;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R10 mode held until line event", {7'd0, pix_en_o}, 8'd1);
    end
  endtask

  task automatic test_sync_line(logic pol, logic esel, logic inv);
    logic rise;
    string tag;
    rise = ~(pol ^ esel);
    tag = $sformatf("R4/R5 pol%0d esel%0d inv%0d", pol, esel, inv);
    mode_i = 2'b01;
    sync_pol_i = pol;
    edge_sel_i = esel;
    chroma_inv_i = inv;
    hsync_i = ~rise;
    repeat (6) tick();
    hsync_i = rise;
    repeat (5) tick();
    chk({tag, " phase at reset edge"}, {7'd0, phase_o}, {7'd0, inv});
    feed_and_check_pairs(inv ? {tag, " R7"} : {tag, " R6"}, inv);
    // opposite transition would reload phase at an odd edge
    hsync_i = ~rise;
    repeat (5) tick();
    chk({tag, " R5 other edge ignored"}, {7'd0, phase_o}, {7'd0, ~inv});
  endtask

  task automatic test_embedded(logic inv);
    logic [7:0] pre [4];
    logic [7:0] eav [5];
    pre[0] = 8'hFF; pre[1] = 8'h00; pre[2] = 8'h00; pre[3] = 8'h80;
    eav[0] = 8'h20; eav[1] = 8'hFF; eav[2] = 8'h00; eav[3] = 8'h00; eav[4] = 8'h9D;
    mode_i = 2'b10;
    sync_pol_i = 1'b0;
    edge_sel_i = 1'b0;
    chroma_inv_i = inv;
    hsync_i = 1'b0;
    repeat (6) tick();
    for (int i = 0; i < 4; i++) begin
      data_i = pre[i];
      tick();
    end
    chk($sformatf("R8 phase at SAV edge inv%0d", inv), {7'd0, phase_o}, {7'd0, inv});
    feed_and_check_pairs(inv ? "R8 R7 embedded" : "R8 R6 embedded", inv);
    hsync_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      data_i = eav[i];
      tick();
    end
    chk($sformatf("R8 R9 EAV and hsync ignored inv%0d", inv), {7'd0, phase_o}, {7'd0, ~inv});
  endtask

  task automatic test_back_to_full();
    mode_i = 2'b00;
    chroma_inv_i = 1'b0;
    sync_pol_i = 1'b0;
    edge_sel_i = 1'b0;
    hsync_i = 1'b0;
    repeat (6) tick();
    hsync_i = 1'b1;
    repeat (5) tick();
    for (int i = 0; i < 3; i++) begin
      data_i = 8'h50 + 8'(i);
      chroma_i = 8'h60 + 8'(i);
      tick();
      chk("R10 R2 full rate after line event", {7'd0, pix_en_o}, 8'd1);
      chk("R2 y after return", y_o, 8'h50 + 8'(i));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_full_rate();
    test_mode_deferred();
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 2; v++)
          test_sync_line(1'(p), 1'(e), 1'(v));
    test_embedded(1'b0);
    test_embedded(1'b1);
    test_back_to_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule